// File: doc/BRIEF.md
# SPI Transaction Master Sequencer

This block is an SPI master that carries out one complete register-style transaction for each command it accepts. A command names a 6-bit register address, a direction, a stream flag and a byte count. The block opens the transaction by pulling the slave select low. It then sends a header byte built from the command. For a streaming command it sends the count as a length byte next. It finishes with the data exchanges and releases the slave select.

For a write, the data bytes are taken from a byte-stream input through a valid/ready handshake. For a read, MOSI carries zeros during the data exchanges, and each received byte is presented on a byte-stream output with a one-cycle valid. The serial clock idles low. MOSI changes on the rising (leading) edge and MISO is sampled on the falling (trailing) edge, most significant bit first. The serial-clock half-period is set per command by a divider input.

Top module: `spi_txn_master`

## Requirements
- R1: The first exchange of every transaction sends the header byte {addr[5:0], rw, stream} on MOSI, MSB first. Bit 1 is rw (1 = write) and bit 0 is stream (1 = multi-byte).
- R2: SCLK is low whenever SS is high. While SS stays low, MOSI changes only in the cycle where SCLK rises. MISO is sampled in the cycle where SCLK falls.
- R3: A streaming command with count N (1 to 255) sends N as the second exchange, followed by exactly N data exchanges, N+2 exchanges in all, with SS held low throughout.
- R4: A non-streaming command uses exactly two exchanges, a header and one data byte, and its count input is ignored.
- R5: In the data exchanges of a read, MOSI is all zeros. Each received byte appears on rd_data_o with a one-cycle rd_valid_o pulse, in the cycle where SCLK falls on its last bit.
- R6: In the data exchanges of a write, each byte is taken from wr_data_i when wr_valid_i and wr_ready_o are both high, and is sent MSB first in order.
- R7: Every SCLK half-period is DIV+1 clock cycles. DIV is captured when a command is accepted, and later changes to cmd_div_i have no effect on the running transaction.
- R8: SS falls in the cycle a command is accepted, and the first SCLK rise comes DIV+1 cycles later. SS rises DIV+1 cycles after the last SCLK fall, and done_o pulses for one cycle in that same cycle.
- R9: A streaming command with count 0 is taken by the handshake but causes no SS, SCLK or done activity.
- R10: When a write byte is due and wr_valid_i is low, the sequencer stalls with SCLK held low and SS held low until the byte arrives.
- R11: cmd_ready_o is high only while no transaction is in progress, so no command is accepted while SS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready (idle) |
| cmd_addr_i | input | 6 | Register address |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_stream_i | input | 1 | 1 = multi-byte with length exchange |
| cmd_count_i | input | 8 | Data byte count for streaming commands |
| cmd_div_i | input | DIV_W | Half-period divider; the half-period is value+1 clocks |
| wr_data_i | input | 8 | Write byte |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Write byte taken this cycle if valid |
| rd_data_o | output | 8 | Received read byte |
| rd_valid_o | output | 1 | Read byte valid (one-cycle pulse) |
| sclk_o | output | 1 | Serial clock |
| ss_no | output | 1 | Slave select, active low |
| mosi_o | output | 1 | Master out serial data |
| miso_i | input | 1 | Master in serial data |
| done_o | output | 1 | One-cycle pulse when SS is released |

## Verification
The collision of interest is a write-data stall landing on a half-period tick. The rising edge that should start a data byte is due in the same cycle that the sequencer finds no write byte, so the stall and the edge generator compete for that cycle. The bench provokes this by withholding wr_valid_i for ten ticks ahead of the second data byte of a streaming write. It judges the result by sampling SCLK and SS on every withheld cycle and by checking that every byte still arrives intact and in order. A second coincidence is also checked: the falling edge that completes the last read byte is the same edge that moves the sequencer into its trailing wait, and the bench confirms that both the final read pulse and the correctly timed SS release appear.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;
  localparam int ADDR_W = 6;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TRAIL} st_e;
  typedef enum logic [1:0] {PH_HDR, PH_LEN, PH_DATA} ph_e;

  function automatic logic [BYTE_W-1:0] mk_header(logic [ADDR_W-1:0] addr, logic wr, logic stream);
    return {addr, wr, stream};
  endfunction
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  // hold keeps the tick asserted until the stall clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (tick_o && !hold_i) cnt_q <= '0;
    else if (!tick_o)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         load_i,
  input  logic [W-1:0] byte_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_next_o,
  output logic         first_o,
  output logic         last_o
);
  localparam int BW = $clog2(W);

  logic [W-2:0]  tx_sh_q;
  logic [W-2:0]  rx_sh_q;
  logic [BW-1:0] bcnt_q;

  assign rx_next_o = {rx_sh_q, miso_i};
  assign first_o   = (bcnt_q == '0);
  assign last_o    = (bcnt_q == BW'(W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mosi_o  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      bcnt_q  <= '0;
    end else if (clr_i) begin
      mosi_o <= 1'b0;
      bcnt_q <= '0;
    end else begin
      if (rise_i) begin
        if (load_i) begin
          mosi_o  <= byte_i[W-1];
          tx_sh_q <= byte_i[W-2:0];
        end else begin
          mosi_o  <= tx_sh_q[W-2];
          tx_sh_q <= {tx_sh_q[W-3:0], 1'b0};
        end
      end
      if (fall_i) begin
        rx_sh_q <= rx_next_o[W-2:0];
        bcnt_q  <= last_o ? '0 : bcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_txn_master.sv
module spi_txn_master
  import spi_txn_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_write_i,
  input  logic              cmd_stream_i,
  input  logic [BYTE_W-1:0] cmd_count_i,
  input  logic [DIV_W-1:0]  cmd_div_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              sclk_o,
  output logic              ss_no,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              done_o
);
  st_e               state_q;
  ph_e               phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, stream_q;
  logic [BYTE_W-1:0] count_q, rem_q;
  logic [DIV_W-1:0]  div_q;

  logic tick, in_run, need_wr, stall, rise, fall, load, clr;
  logic first, last;
  logic [BYTE_W-1:0] tx_byte, rx_next;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign in_run      = (state_q == ST_RUN);
  assign need_wr     = (phase_q == PH_DATA) && wr_q;

  // byte is due on the rising edge that starts a new exchange
  assign wr_ready_o = in_run && tick && !sclk_o && first && need_wr;
  assign stall      = wr_ready_o && !wr_valid_i;
  assign rise       = in_run && tick && !sclk_o && !stall;
  assign load       = rise && first;
  assign fall       = in_run && tick && sclk_o;
  assign clr        = (state_q == ST_IDLE) || ((state_q == ST_TRAIL) && tick);

  always_comb begin
    unique case (phase_q)
      PH_HDR:  tx_byte = mk_header(addr_q, wr_q, stream_q);
      PH_LEN:  tx_byte = count_q;
      default: tx_byte = wr_q ? wr_data_i : '0;
    endcase
  end

  spi_half_timer #(.DIV_W(DIV_W)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .hold_i (stall),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_byte_shifter #(.W(BYTE_W)) shifter_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .rise_i    (rise),
    .fall_i    (fall),
    .load_i    (load),
    .byte_i    (tx_byte),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_next_o (rx_next),
    .first_o   (first),
    .last_o    (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_HDR;
      addr_q     <= '0;
      wr_q       <= 1'b0;
      stream_q   <= 1'b0;
      count_q    <= '0;
      rem_q      <= '0;
      div_q      <= '0;
      sclk_o     <= 1'b0;
      ss_no      <= 1'b1;
      done_o     <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      done_o     <= 1'b0;
      rd_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          // zero-length stream is consumed without bus activity
          if (cmd_valid_i && !(cmd_stream_i && cmd_count_i == '0)) begin
            state_q  <= ST_RUN;
            phase_q  <= PH_HDR;
            addr_q   <= cmd_addr_i;
            wr_q     <= cmd_write_i;
            stream_q <= cmd_stream_i;
            count_q  <= cmd_count_i;
            div_q    <= cmd_div_i;
            ss_no    <= 1'b0;
          end
        end
        ST_RUN: begin
          if (rise) sclk_o <= 1'b1;
          if (fall) begin
            sclk_o <= 1'b0;
            if (last) begin
              unique case (phase_q)
                PH_HDR: begin
                  phase_q <= stream_q ? PH_LEN : PH_DATA;
                  rem_q   <= BYTE_W'(1);
                end
                PH_LEN: begin
                  phase_q <= PH_DATA;
                  rem_q   <= count_q;
                end
                default: begin
                  if (!wr_q) begin
                    rd_valid_o <= 1'b1;
                    rd_data_o  <= rx_next;
                  end
                  if (rem_q == BYTE_W'(1)) state_q <= ST_TRAIL;
                  else                     rem_q   <= rem_q - 1'b1;
                end
              endcase
            end
          end
        end
        default: begin
          if (tick) begin
            state_q <= ST_IDLE;
            ss_no   <= 1'b1;
            done_o  <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_txn_master_chk.sv
module spi_txn_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_ready_o,
  input logic wr_valid_i,
  input logic wr_ready_o,
  input logic rd_valid_o,
  input logic sclk_o,
  input logic ss_no,
  input logic mosi_o,
  input logic done_o
);
  // R2
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !sclk_o);

  // R2
  mosi_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_no && !$past(ss_no) && (mosi_o != $past(mosi_o))) |-> $rose(sclk_o));

  // R5
  rd_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($fell(sclk_o) && !ss_no));

  // R8
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ss_no && !$past(ss_no)));

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ready_o && !wr_valid_i) |=> (!sclk_o && !ss_no));

  // R11
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_no |-> !cmd_ready_o);
endmodule

bind spi_txn_master spi_txn_master_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_ready_o (cmd_ready_o),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .rd_valid_o  (rd_valid_o),
  .sclk_o      (sclk_o),
  .ss_no       (ss_no),
  .mosi_o      (mosi_o),
  .done_o      (done_o)
);

// File: tb/spi_txn_master_tb_top.sv
module spi_txn_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N      = 300;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0, cmd_ready_o;
  logic [5:0] cmd_addr_i = '0;
  logic cmd_write_i = 1'b0, cmd_stream_i = 1'b0;
  logic [7:0] cmd_count_i = '0, cmd_div_i = '0;
  logic [7:0] wr_data_i = '0;
  logic wr_valid_i = 1'b0, wr_ready_o;
  logic [7:0] rd_data_o;
  logic rd_valid_o, sclk_o, ss_no, mosi_o, done_o;
  logic miso_i = 1'b0;

  spi_txn_master dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int cyc = 0;

  function automatic logic [7:0] pat(int e);
    return 8'(e * 41 + 92);
  endfunction
  function automatic logic [7:0] wbyte(int k);
    return 8'(k * 59) ^ 8'hC6;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // slave model: drive on rising edge, sample on falling edge
  int sex = 0, sbit = 0, nex = 0;
  logic [7:0] mb = '0;
  logic [7:0] mlog [LOG_N];
  always @(negedge ss_no) begin sex = 0; sbit = 0; nex = 0; end
  always @(posedge sclk_o) miso_i = pat(sex)[7 - sbit];
  always @(negedge sclk_o) begin
    mb = {mb[6:0], mosi_o};
    sbit++;
    if (sbit == 8) begin
      if (nex < LOG_N) mlog[nex] = mb;
      nex++; sex++; sbit = 0;
    end
  end

  // read capture, done and timing monitors
  int rd_cnt = 0, done_cnt = 0, done_bad = 0, terr = 0, gap = 0, exp_half = 1;
  bit tmon_en = 1'b0;
  logic p_ss = 1'b1, p_sclk = 1'b0;
  logic [7:0] rlog [LOG_N];
  always @(negedge clk_i) begin
    if (rd_valid_o) begin
      if (rd_cnt < LOG_N) rlog[rd_cnt] = rd_data_o;
      rd_cnt++;
    end
    if (done_o) begin
      done_cnt++;
      if (!ss_no) done_bad++;
    end
    if (p_ss && !ss_no) gap = 0;
    else if (sclk_o != p_sclk || ss_no != p_ss) begin
      if (tmon_en && gap + 1 != exp_half) terr++;
      gap = 0;
    end else gap++;
    p_ss = ss_no; p_sclk = sclk_o;
  end

  // write byte source
  int wr_n = 0, wr_idx = 0, stall_at = -1, stall_left = 0, stall_obs = 0, stall_bad = 0;
  bit wr_pend = 1'b0;
  always @(negedge clk_i) begin
    if (wr_pend) begin wr_idx++; wr_pend = 1'b0; end
    if (wr_idx < wr_n && !(wr_idx == stall_at && stall_left > 0)) begin
      wr_valid_i = 1'b1; wr_data_i = wbyte(wr_idx);
    end else wr_valid_i = 1'b0;
    if (wr_idx == stall_at && stall_left > 0 && wr_ready_o) begin
      stall_left--; stall_obs++;
      if (sclk_o || ss_no) stall_bad++;
    end
    wr_pend = wr_valid_i && wr_ready_o;
  end

  task automatic run_txn(input logic [5:0] a, input bit w, input bit s, input logic [7:0] n,
                         input logic [7:0] dv, input int st_at, input int st_len);
    int exp_ex, ndat, base, d0, to;
    ndat = s ? int'(n) : 1;
    exp_ex = ndat + (s ? 2 : 1);
    base = s ? 2 : 1;
    @(negedge clk_i);
    wr_n = w ? ndat : 0; wr_idx = 0; wr_pend = 1'b0;
    stall_at = st_at; stall_left = st_len; stall_obs = 0; stall_bad = 0;
    rd_cnt = 0; terr = 0; done_bad = 0; exp_half = int'(dv) + 1; tmon_en = (st_len == 0);
    d0 = done_cnt;
    cmd_valid_i = 1'b1; cmd_addr_i = a; cmd_write_i = w; cmd_stream_i = s;
    cmd_count_i = n; cmd_div_i = dv;
    chk(cmd_ready_o == 1'b1, "R11 ready idle", int'(cmd_ready_o), 1);
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_div_i = ~dv; cmd_count_i = 8'h00; // R7 later div change ignored
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b0 && ss_no == 1'b0, "R11 ready busy", int'({cmd_ready_o, ss_no}), 0);
    to = 0;
    while (done_cnt == d0 && to < 20000) begin @(negedge clk_i); to++; end
    chk(done_cnt == d0 + 1, "R8 done pulse", done_cnt - d0, 1);
    chk(done_bad == 0, "R8 done with SS high", done_bad, 0);
    if (tmon_en) chk(terr == 0, "R7 R8 half period timing", terr, 0);
    chk(nex == exp_ex, s ? "R3 exchange count" : "R4 exchange count", nex, exp_ex);
    chk(mlog[0] == {a, w, s}, "R1 header", int'(mlog[0]), int'({a, w, s}));
    if (s) chk(mlog[1] == n, "R3 length byte", int'(mlog[1]), int'(n));
    if (w) begin
      for (int k = 0; k < ndat; k++)
        chk(mlog[base + k] == wbyte(k), "R6 write byte", int'(mlog[base + k]), int'(wbyte(k)));
      chk(rd_cnt == 0, "R6 no read pulses", rd_cnt, 0);
    end else begin
      chk(rd_cnt == ndat, "R5 read count", rd_cnt, ndat);
      for (int k = 0; k < ndat; k++) begin
        chk(mlog[base + k] == 8'h00, "R5 MOSI zero", int'(mlog[base + k]), 0);
        chk(rlog[k] == pat(base + k), "R5 read byte", int'(rlog[k]), int'(pat(base + k)));
      end
    end
    if (st_len > 0) begin
      chk(stall_obs == st_len, "R10 stall cycles", stall_obs, st_len);
      chk(stall_bad == 0, "R10 SCLK low SS low in stall", stall_bad, 0);
    end
    chk(ss_no == 1'b1 && sclk_o == 1'b0 && mosi_o == 1'b0, "R2 idle lines",
        int'({ss_no, sclk_o, mosi_o}), 4);
  endtask

  initial begin
    int bad, d0;
    logic [7:0] dv;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ss_no == 1'b1 && sclk_o == 1'b0 && mosi_o == 1'b0, "R2 reset lines",
        int'({ss_no, sclk_o, mosi_o}), 4);
    chk(cmd_ready_o == 1'b1 && done_o == 1'b0 && rd_valid_o == 1'b0, "R11 reset outputs",
        int'({cmd_ready_o, done_o, rd_valid_o}), 4);

    for (int di = 0; di < 4; di++) begin
      dv = (di == 3) ? 8'd5 : 8'(di);
      for (int kd = 0; kd < 8; kd++) begin
        logic [5:0] a;
        a = 6'((di * 8 + kd) * 13 + 5);
        if (kd < 2) run_txn(a, kd[0], 1'b0, 8'd7, dv, -1, 0);
        else if (kd < 5) run_txn(a, 1'b0, 1'b1, 8'(kd - 1), dv, -1, 0);
        else run_txn(a, 1'b1, 1'b1, 8'(kd - 4), dv, -1, 0);
      end
    end

    // R3 boundary: maximum stream length
    run_txn(6'h3F, 1'b0, 1'b1, 8'd255, 8'd0, -1, 0);
    run_txn(6'h00, 1'b1, 1'b1, 8'd255, 8'd0, -1, 0);
    // R4 count ignored for single-byte command
    run_txn(6'h16, 1'b0, 1'b0, 8'd0, 8'd1, -1, 0);

    // R9 zero-length stream rejected
    @(negedge clk_i);
    d0 = done_cnt;
    cmd_valid_i = 1'b1; cmd_addr_i = 6'h2A; cmd_write_i = 1'b0; cmd_stream_i = 1'b1;
    cmd_count_i = 8'd0; cmd_div_i = 8'd0;
    chk(cmd_ready_o == 1'b1, "R9 handshake taken", int'(cmd_ready_o), 1);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (!ss_no || sclk_o || !cmd_ready_o) bad++;
    end
    chk(bad == 0, "R9 no bus activity", bad, 0);
    chk(done_cnt == d0, "R9 no done", done_cnt - d0, 0);

    // R10 write data withheld while a rising edge is due
    run_txn(6'h3D, 1'b1, 1'b1, 8'd3, 8'd2, 1, 10);
    run_txn(6'h11, 1'b1, 1'b0, 8'd0, 8'd0, 0, 6);

    finish_run();
  end
endmodule